// File: doc/BRIEF.md
# Level-Sensitive Interrupt Bank with Three Routed Outputs

This block collects a vector of level-sensitive interrupt sources and presents them to three destinations: a normal interrupt line, a fast interrupt line and an endpoint line. Every clock the sampled source levels land in a shared cause register. The cause register holds no history: a bit is set while its source is high and clears as soon as the source falls. Each destination has its own mask register. A destination line is high whenever any cause bit is set whose bit in that destination's mask is also set.

Software reaches the bank through a small register port: a byte offset, a write enable, write data and combinational read data. A mask bit of 1 lets the matching source through and a 0 blocks it. All masks come out of reset at zero, so no destination is driven until software opens one. The block also gives the number of the highest pending source on the normal line, with a valid flag, so a handler can go straight to that source.

Top module: `intc_bank`

## Requirements
- R1: Cause bit n equals the level of source n sampled at the previous rising clock edge, so it clears one cycle after the source drops. Reading offset 0x0 returns the cause register.
- R2: The normal interrupt output is high exactly when cause AND the normal mask (offset 0x4) is nonzero. Mask bit n set to 1 enables source n.
- R3: The fast interrupt output is high exactly when cause AND the fast mask (offset 0x8) is nonzero.
- R4: The endpoint output is high exactly when cause AND the endpoint mask (offset 0xC) is nonzero.
- R5: A write with the write enable high at offset 0x4, 0x8 or 0xC loads that mask on the clock edge. Reading the same offset returns the stored value, with bit n belonging to source n.
- R6: After reset all three masks read zero, and all three outputs and the pending-valid flag stay low even while every source is high.
- R7: When cause AND the normal mask is nonzero, the pending index output gives the highest-numbered set bit of that product and the valid flag is high. Otherwise the valid flag is low and the index is zero.
- R8: Writes to offset 0x0 change nothing: the cause register and every output keep following the sources.
- R9: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return zero, and writes to such offsets leave all masks unchanged.
- R10: Writing zero to a mask turns that destination's output off on the next cycle, even while its sources stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for the addressed register, combinational |
| src_i | input | NUM_SRC | Level of each interrupt source |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| endp_o | output | 1 | Endpoint interrupt line |
| pend_idx_o | output | IDX_W | Number of the highest pending source on the normal line |
| pend_vld_o | output | 1 | Pending index is valid |

## Verification
The bench builds the bank with NUM_SRC = 8. At that width every one of the 256 source patterns can be crossed with every one of the 256 normal-mask values, and the fast and endpoint masks are derived arithmetically from each normal mask. Every combination of priority-encoder input and gating result therefore gets exercised, including the empty and all-ones cases. The small width also makes it cheap to go through all twelve unmapped offsets for both reads and writes.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned OFF_W   = 4;
    localparam int unsigned NUM_DST = 3;

    localparam logic [OFF_W-1:0] OFF_CAUSE = 4'h0;
    localparam logic [OFF_W-1:0] OFF_IRQ   = 4'h4;
    localparam logic [OFF_W-1:0] OFF_FIQ   = 4'h8;
    localparam logic [OFF_W-1:0] OFF_ENDP  = 4'hC;

    typedef enum logic [1:0] {
        DST_IRQ  = 2'd0,
        DST_FIQ  = 2'd1,
        DST_ENDP = 2'd2
    } dest_e;

    // Mask registers follow the cause register at a 4-byte stride.
    function automatic logic [OFF_W-1:0] dst_off(input int unsigned d);
        return OFF_IRQ + OFF_W'(d * 4);
    endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [OFF_W-1:0]                  wr_addr,
    input  logic [NUM_SRC-1:0]                wr_data,
    output logic [NUM_DST-1:0][NUM_SRC-1:0]   mask_o
);

    typedef struct packed {
        logic [NUM_DST-1:0][NUM_SRC-1:0] mask;
    } mask_state_t;

    mask_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int unsigned d = 0; d < NUM_DST; d++) begin
                if (wr_addr == dst_off(d)) begin
                    state_d.mask[d] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;

    for (genvar g = 0; g < NUM_DST; g++) begin : g_hold
        AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_addr == dst_off(g)) |=> $stable(mask_o[g])); // R9
        AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == dst_off(g)) |=> mask_o[g] == $past(wr_data)); // R5
    end

endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]                cause_i,
    input  logic [NUM_DST-1:0][NUM_SRC-1:0]   mask_i,
    output logic [NUM_DST-1:0]                line_o
);

    for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
        assign line_o[g] = |(cause_i & mask_i[g]);
    end

endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o
);

    // Scan upward so the highest set bit is the last one to win.
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int unsigned i = 0; i < WIDTH; i++) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
                vld_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter  int unsigned NUM_SRC = 32,
    localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         reg_addr,
    input  logic               reg_we,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               endp_o,
    output logic [IDX_W-1:0]   pend_idx_o,
    output logic               pend_vld_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] cause;
    } bank_state_t;

    bank_state_t state_d, state_q;

    logic [NUM_DST-1:0][NUM_SRC-1:0] mask;
    logic [NUM_DST-1:0]              line;
    logic [NUM_SRC-1:0]              irq_gated;

    // Cause is a plain sample of the sources; software cannot write it.
    always_comb begin
        state_d       = state_q;
        state_d.cause = src_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    intc_mask_bank #(.NUM_SRC(NUM_SRC)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .mask_o  (mask)
    );

    intc_route #(.NUM_SRC(NUM_SRC)) u_route (
        .cause_i (state_q.cause),
        .mask_i  (mask),
        .line_o  (line)
    );

    assign irq_gated = state_q.cause & mask[DST_IRQ];

    intc_prio_enc #(.WIDTH(NUM_SRC), .IDX_W(IDX_W)) u_enc (
        .vec_i (irq_gated),
        .idx_o (pend_idx_o),
        .vld_o (pend_vld_o)
    );

    assign irq_o  = line[DST_IRQ];
    assign fiq_o  = line[DST_FIQ];
    assign endp_o = line[DST_ENDP];

    always_comb begin
        unique case (reg_addr)
            OFF_CAUSE: reg_rdata = state_q.cause;
            OFF_IRQ:   reg_rdata = mask[DST_IRQ];
            OFF_FIQ:   reg_rdata = mask[DST_FIQ];
            OFF_ENDP:  reg_rdata = mask[DST_ENDP];
            default:   reg_rdata = '0;
        endcase
    end

    AST_CAUSE_TRACK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> state_q.cause == $past(src_i)); // R1
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq_o && !fiq_o && !endp_o && !pend_vld_o); // R6
    AST_PEND_MATCH: assert property (@(posedge clk) disable iff (rst)
        pend_vld_o == irq_o); // R7
    AST_PEND_TOP: assert property (@(posedge clk) disable iff (rst)
        pend_vld_o |-> (irq_gated >> pend_idx_o) == NUM_SRC'(1)); // R7
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst)
        (mask[DST_IRQ] == '0) |-> !irq_o); // R10

endmodule

// File: tb/tb_intc_bank.sv
`timescale 1ns/1ps
module tb_intc_bank;

    localparam int unsigned NS = 8;
    localparam int unsigned IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    reg_addr = 4'h0;
    logic          reg_we = 1'b0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic [NS-1:0] src_i = '0;
    logic          irq_o, fiq_o, endp_o, pend_vld_o;
    logic [IW-1:0] pend_idx_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    intc_bank #(.NUM_SRC(NS)) dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_i(src_i),
        .irq_o(irq_o), .fiq_o(fiq_o), .endp_o(endp_o),
        .pend_idx_o(pend_idx_o), .pend_vld_o(pend_vld_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NS-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [NS-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int top_bit(input logic [NS-1:0] v);
        int r = -1;
        for (int i = 0; i < NS; i++) if (v[i]) r = i;
        return r;
    endfunction

    initial begin
        #750000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NS-1:0] v;
        src_i = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: reset state
        rd(4'h4, v); check("R6 irq mask", v, 0);
        rd(4'h8, v); check("R6 fiq mask", v, 0);
        rd(4'hC, v); check("R6 endp mask", v, 0);
        check("R6 outputs", {irq_o, fiq_o, endp_o, pend_vld_o}, 0);
        rd(4'h0, v); check("R1 cause all high", v, 8'hFF);

        // R8: writing the cause register does nothing
        wr(4'h0, 8'h00);
        rd(4'h0, v); check("R8 cause after write 0", v, 8'hFF);
        src_i = 8'h00;
        wr(4'h0, 8'hFF);
        rd(4'h0, v); check("R8 cause after write FF", v, 8'h00);
        wr(4'h4, 8'hFF);
        check("R8 irq stays low", irq_o, 0);

        // R5: mask readback
        wr(4'h4, 8'hA5); wr(4'h8, 8'h3C); wr(4'hC, 8'h81);
        rd(4'h4, v); check("R5 irq mask", v, 8'hA5);
        rd(4'h8, v); check("R5 fiq mask", v, 8'h3C);
        rd(4'hC, v); check("R5 endp mask", v, 8'h81);

        // R9: unmapped offsets
        for (int a = 0; a < 16; a++) begin
            if (a % 4 != 0) begin
                wr(4'(a), 8'hFF);
                rd(4'(a), v); check("R9 unmapped read", v, 0);
            end
        end
        rd(4'h4, v); check("R9 irq mask kept", v, 8'hA5);
        rd(4'h8, v); check("R9 fiq mask kept", v, 8'h3C);
        rd(4'hC, v); check("R9 endp mask kept", v, 8'h81);

        // R1: cause clears one cycle after the source drops
        @(negedge clk); reg_addr = 4'h0; src_i = 8'h10;
        @(negedge clk); check("R1 cause set", reg_rdata, 8'h10);
        src_i = 8'h00;
        #1 check("R1 cause holds until edge", reg_rdata, 8'h10);
        @(negedge clk); check("R1 cause cleared", reg_rdata, 8'h00);

        // R10: zero mask silences a held source
        src_i = 8'hFF;
        wr(4'h4, 8'hFF);
        check("R10 irq on", irq_o, 1);
        wr(4'h4, 8'h00);
        check("R10 irq off", irq_o, 0);
        check("R10 pend off", pend_vld_o, 0);

        // R2 R3 R4 R7 R1: full sweep of sources against normal masks
        for (int m = 0; m < 256; m++) begin
            logic [NS-1:0] mi, mf, me;
            mi = 8'(m);
            mf = 8'((m * 37 + 11) & 255);
            me = 8'(m) ^ 8'hC3;
            wr(4'h4, mi); wr(4'h8, mf); wr(4'hC, me);
            reg_addr = 4'h0;
            for (int s = 0; s < 256; s++) begin
                logic [NS-1:0] sv;
                int hb;
                sv = 8'(s);
                src_i = sv;
                @(negedge clk);
                hb = top_bit(sv & mi);
                check("R1 cause", reg_rdata, sv);
                check("R2 irq", irq_o, |(sv & mi));
                check("R3 fiq", fiq_o, |(sv & mf));
                check("R4 endp", endp_o, |(sv & me));
                check("R7 valid", pend_vld_o, hb >= 0);
                check("R7 index", pend_idx_o, (hb >= 0) ? hb : 0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule